// File: doc/BRIEF.md
# AXI4-Lite to Register Bridge Across Clock Domains

This block is a 32-bit AXI4-Lite slave that lives in a CPU clock domain and turns each accepted transaction into one access on a simple register port in an unrelated user clock domain. The register port has one word address shared by writes and reads. A write shows up as a one-cycle write strobe with data and byte enables. A read shows up as a one-cycle read request, and the slave answers whenever it is ready with a valid strobe and the data.

Each of the five AXI channels has its own logic. The write address, write data and read address channels each latch one beat into a holding register. A CPU-side state machine launches one request at a time toward the user domain. It uses a toggle line that passes through a two-stage synchronizer, and it waits for a toggle acknowledge to come back the same way. Writes are acknowledged only after the user-domain strobe has happened. Read data is captured in the user domain when the slave signals valid, and the CPU side samples it once the acknowledge arrives.

CPU-side states: C_IDLE moves to C_WR_WAIT when both write beats are held, or else to C_RD_WAIT when a read address is held. C_WR_WAIT moves to C_WR_RESP on acknowledge. C_WR_RESP moves to C_IDLE when bready is high. C_RD_WAIT moves to C_RD_RESP on acknowledge. C_RD_RESP moves to C_IDLE when rready is high. User-side states: U_IDLE moves to U_WRITE or U_RD_REQ when a new request toggle is seen. U_WRITE returns to U_IDLE and toggles the acknowledge. U_RD_REQ moves to U_RD_WAIT. U_RD_WAIT returns to U_IDLE on reg_rd_valid and toggles the acknowledge.

Top module: `axil_cdc_regbridge`

## Requirements
- R1: Write address and write data are accepted independently, in either order or together. Once a channel holds a beat, its ready (awready or wready) stays low until that write's response has been taken.
- R2: Each write produces exactly one user-clock cycle of reg_wr_en. During that cycle reg_addr equals awaddr[15:2], reg_wr_data equals wdata, and reg_wr_be equals wstrb, where bit n of reg_wr_be qualifies data bits [8n+7:8n].
- R3: bvalid rises only after the user-domain write strobe. bresp is 2'b00 (OKAY). bvalid stays high until bready is sampled high, and it is low in the cycle after that handshake.
- R4: Each read produces exactly one user-clock cycle of reg_rd_req with reg_addr equal to araddr[15:2]. reg_addr then stays constant until reg_rd_valid is returned.
- R5: rdata equals the reg_rd_data presented with reg_rd_valid, and rresp is 2'b00 (OKAY). rvalid and rdata are held until rready is sampled high.
- R6: When a complete write and a read are both held, the write is performed on the register port first. reg_wr_en and reg_rd_req are never high together, and every accepted transaction produces exactly one register access.
- R7: After reset, awready, wready and arready are high, and bvalid and rvalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-domain clock |
| cpu_rst_n | input | 1 | CPU-domain reset, active low |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 16 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 16 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| usr_clk | input | 1 | User-domain clock |
| usr_rst_n | input | 1 | User-domain reset, active low |
| reg_addr | output | 14 | Shared word address |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 32 | Write data |
| reg_wr_be | output | 4 | Write byte enables |
| reg_rd_req | output | 1 | One-cycle read request |
| reg_rd_data | input | 32 | Read data from the register slave |
| reg_rd_valid | input | 1 | Read data valid from the register slave |

## Verification
The assertions assume that the AXI master presents only word-aligned addresses. They also assume that the register slave raises reg_rd_valid at least one user clock after reg_rd_req, and raises it only for an outstanding read. The bench's master drives addresses with the two low bits at zero. Its slave model answers exactly one user clock after each request, using data computed from the latched address. The bench runs the two clocks at unrelated periods, so the toggle crossings see many different phase alignments.

// File: rtl/regbr_pkg.sv
`timescale 1ns/1ps
package regbr_pkg;
    typedef enum logic [2:0] {
        C_IDLE, C_WR_WAIT, C_WR_RESP, C_RD_WAIT, C_RD_RESP
    } cpu_st_e;

    typedef enum logic [1:0] {
        U_IDLE, U_WRITE, U_RD_REQ, U_RD_WAIT
    } usr_st_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/regbr_tsync.sv
`timescale 1ns/1ps
module regbr_tsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/regbr_cpu_fsm.sv
`timescale 1ns/1ps
module regbr_cpu_fsm import regbr_pkg::*; #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8,
    parameter int WA_W   = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   wstrb,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              req_tgl,
    output logic              req_rd,
    output logic [WA_W-1:0]   req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [BE_W-1:0]   req_be,
    input  logic              ack_s,
    input  logic [DATA_W-1:0] rd_hold
);
    cpu_st_e st, st_nx;
    logic aw_full, w_full, ar_full;
    logic [WA_W-1:0]   aw_word, ar_word;
    logic [DATA_W-1:0] w_data, rd_q;
    logic [BE_W-1:0]   w_be;
    logic done, go_wr, go_rd;

    assign done  = (req_tgl == ack_s);
    assign go_wr = aw_full && w_full;
    assign go_rd = ar_full && !go_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            C_IDLE:    if (go_wr) st_nx = C_WR_WAIT;
                       else if (go_rd) st_nx = C_RD_WAIT;
            C_WR_WAIT: if (done) st_nx = C_WR_RESP;
            C_WR_RESP: if (bready) st_nx = C_IDLE;
            C_RD_WAIT: if (done) st_nx = C_RD_RESP;
            C_RD_RESP: if (rready) st_nx = C_IDLE;
            default:   st_nx = C_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        awready = !aw_full;
        wready  = !w_full;
        arready = !ar_full;
        bvalid  = (st == C_WR_RESP);
        rvalid  = (st == C_RD_RESP);
        bresp   = RESP_OKAY;
        rresp   = RESP_OKAY;
        rdata   = rd_q;
    end

    // channel holding registers and request launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aw_full  <= 1'b0;
            w_full   <= 1'b0;
            ar_full  <= 1'b0;
            aw_word  <= '0;
            ar_word  <= '0;
            w_data   <= '0;
            w_be     <= '0;
            req_tgl  <= 1'b0;
            req_rd   <= 1'b0;
            req_addr <= '0;
            req_data <= '0;
            req_be   <= '0;
            rd_q     <= '0;
        end else begin
            if (awvalid && !aw_full) begin
                aw_full <= 1'b1;
                aw_word <= awaddr[ADDR_W-1:2];
            end else if (st == C_WR_RESP && bready) begin
                aw_full <= 1'b0;
            end
            if (wvalid && !w_full) begin
                w_full <= 1'b1;
                w_data <= wdata;
                w_be   <= wstrb;
            end else if (st == C_WR_RESP && bready) begin
                w_full <= 1'b0;
            end
            if (arvalid && !ar_full) begin
                ar_full <= 1'b1;
                ar_word <= araddr[ADDR_W-1:2];
            end else if (st == C_RD_RESP && rready) begin
                ar_full <= 1'b0;
            end
            if (st == C_IDLE && (go_wr || go_rd)) begin
                req_tgl  <= ~req_tgl;
                req_rd   <= !go_wr;
                req_addr <= go_wr ? aw_word : ar_word;
                req_data <= w_data;
                req_be   <= w_be;
            end
            if (st == C_RD_WAIT && done) rd_q <= rd_hold;
        end
    end

    // R1 input assumption: byte addresses are word aligned
    a_r1_aw_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (awaddr[1:0] == 2'b00));
    // R4 input assumption: byte addresses are word aligned
    a_r4_ar_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid |-> (araddr[1:0] == 2'b00));
    a_r3_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);
    a_r5_rvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));
    a_r6_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_IDLE && aw_full && w_full && ar_full) |=> (st == C_WR_WAIT && !req_rd));
endmodule

// File: rtl/regbr_usr_fsm.sv
`timescale 1ns/1ps
module regbr_usr_fsm import regbr_pkg::*; #(
    parameter int WA_W   = 14,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic              req_rd,
    input  logic [WA_W-1:0]   req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [BE_W-1:0]   req_be,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] rd_hold,
    output logic [WA_W-1:0]   reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [BE_W-1:0]   reg_wr_be,
    output logic              reg_rd_req,
    input  logic [DATA_W-1:0] reg_rd_data,
    input  logic              reg_rd_valid
);
    usr_st_e st, st_nx;
    logic fresh;

    assign fresh = (req_s != ack_tgl);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= U_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            U_IDLE:    if (fresh) st_nx = req_rd ? U_RD_REQ : U_WRITE;
            U_WRITE:   st_nx = U_IDLE;
            U_RD_REQ:  st_nx = U_RD_WAIT;
            U_RD_WAIT: if (reg_rd_valid) st_nx = U_IDLE;
            default:   st_nx = U_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        reg_wr_en  = (st == U_WRITE);
        reg_rd_req = (st == U_RD_REQ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_tgl     <= 1'b0;
            rd_hold     <= '0;
            reg_addr    <= '0;
            reg_wr_data <= '0;
            reg_wr_be   <= '0;
        end else begin
            if (st == U_IDLE && fresh) begin
                reg_addr    <= req_addr;
                reg_wr_data <= req_data;
                reg_wr_be   <= req_be;
            end
            if (st == U_WRITE) ack_tgl <= ~ack_tgl;
            if (st == U_RD_WAIT && reg_rd_valid) begin
                rd_hold <= reg_rd_data;
                ack_tgl <= ~ack_tgl;
            end
        end
    end

    a_r2_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    a_r4_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_req |=> !reg_rd_req);
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == U_RD_WAIT) |-> $stable(reg_addr));
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_req));
endmodule

// File: rtl/axil_cdc_regbridge.sv
`timescale 1ns/1ps
module axil_cdc_regbridge #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                cpu_clk,
    input  logic                cpu_rst_n,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_wvalid,
    output logic                s_wready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    output logic                s_bvalid,
    input  logic                s_bready,
    output logic [1:0]          s_bresp,
    input  logic                s_arvalid,
    output logic                s_arready,
    input  logic [ADDR_W-1:0]   s_araddr,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    input  logic                usr_clk,
    input  logic                usr_rst_n,
    output logic [ADDR_W-3:0]   reg_addr,
    output logic                reg_wr_en,
    output logic [DATA_W-1:0]   reg_wr_data,
    output logic [DATA_W/8-1:0] reg_wr_be,
    output logic                reg_rd_req,
    input  logic [DATA_W-1:0]   reg_rd_data,
    input  logic                reg_rd_valid
);
    localparam int BE_W = DATA_W / 8;
    localparam int WA_W = ADDR_W - 2;

    logic              req_tgl, req_s, req_rd, ack_tgl, ack_s;
    logic [WA_W-1:0]   req_addr;
    logic [DATA_W-1:0] req_data, rd_hold;
    logic [BE_W-1:0]   req_be;

    regbr_cpu_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .WA_W(WA_W)) u_cpu (
        .clk(cpu_clk), .rst_n(cpu_rst_n),
        .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
        .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
        .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
        .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
        .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
        .req_tgl(req_tgl), .req_rd(req_rd), .req_addr(req_addr),
        .req_data(req_data), .req_be(req_be), .ack_s(ack_s), .rd_hold(rd_hold)
    );

    regbr_tsync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(usr_clk), .rst_n(usr_rst_n), .d(req_tgl), .q(req_s)
    );

    regbr_tsync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack_tgl), .q(ack_s)
    );

    regbr_usr_fsm #(.WA_W(WA_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_usr (
        .clk(usr_clk), .rst_n(usr_rst_n), .req_s(req_s), .req_rd(req_rd),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .ack_tgl(ack_tgl), .rd_hold(rd_hold), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be),
        .reg_rd_req(reg_rd_req), .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid)
    );
endmodule

// File: tb/sim_axil_cdc_regbridge.sv
`timescale 1ns/1ps
module sim_axil_cdc_regbridge;
    typedef struct packed {
        logic        rd;
        logic [13:0] a;
        logic [31:0] d;
        logic [3:0]  be;
    } item_t;

    logic cpu_clk = 1'b0, usr_clk = 1'b0;
    logic cpu_rst_n = 1'b0, usr_rst_n = 1'b0;
    logic s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
    logic s_bready = 1'b0, s_rready = 1'b0;
    logic [15:0] s_awaddr = '0, s_araddr = '0;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic s_awready, s_wready, s_arready, s_bvalid, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic [13:0] reg_addr;
    logic reg_wr_en, reg_rd_req;
    logic [31:0] reg_wr_data, reg_rd_data;
    logic [3:0]  reg_wr_be;
    logic reg_rd_valid = 1'b0;
    logic [13:0] lat_addr = '0;

    int unsigned n_tests = 0, n_fail = 0;
    item_t q[$];

    always #2 cpu_clk = ~cpu_clk;   // 250 MHz
    always #3.5 usr_clk = ~usr_clk;

    axil_cdc_regbridge u0 (
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .usr_clk(usr_clk), .usr_rst_n(usr_rst_n),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_wr_be(reg_wr_be), .reg_rd_req(reg_rd_req),
        .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid)
    );

    function automatic logic [31:0] pat(input logic [13:0] a);
        return {8'hA5, 10'd0, a};
    endfunction

    assign reg_rd_data = pat(lat_addr);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // register slave: answers one user clock after each request
    always @(posedge usr_clk) begin
        reg_rd_valid <= reg_rd_req;
        if (reg_rd_req) lat_addr <= reg_addr;
    end

    // monitor / scoreboard on the register side
    logic prev_wr = 1'b0;
    always @(negedge usr_clk) begin
        item_t e;
        if (usr_rst_n) begin
            if (prev_wr && reg_wr_en) chk("R2 wr strobe longer than one cycle", 1, 0);
            if (reg_wr_en || reg_rd_req) begin
                if (q.size() == 0) begin
                    chk("R6 unexpected register access", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk("R6 access kind/order", {63'd0, reg_rd_req}, {63'd0, e.rd});
                    if (!e.rd) begin
                        chk("R2 write addr", {50'd0, reg_addr}, {50'd0, e.a});
                        chk("R2 write data", {32'd0, reg_wr_data}, {32'd0, e.d});
                        chk("R2 write byte enable", {60'd0, reg_wr_be}, {60'd0, e.be});
                    end else begin
                        chk("R4 read addr", {50'd0, reg_addr}, {50'd0, e.a});
                    end
                end
            end
            if (reg_rd_valid) chk("R4 addr held until valid", {50'd0, reg_addr}, {50'd0, lat_addr});
            prev_wr <= reg_wr_en;
        end
    end

    task automatic hs(input logic doaw, input logic dow, input logic doar);
        @(negedge cpu_clk);
        s_awvalid = doaw; s_wvalid = dow; s_arvalid = doar;
        while (s_awvalid || s_wvalid || s_arvalid) begin
            logic a_h, w_h, r_h;
            a_h = s_awvalid && s_awready;
            w_h = s_wvalid && s_wready;
            r_h = s_arvalid && s_arready;
            @(negedge cpu_clk);
            if (a_h) s_awvalid = 1'b0;
            if (w_h) s_wvalid = 1'b0;
            if (r_h) s_arvalid = 1'b0;
        end
    endtask

    // mode 0: AW and W together, 1: AW first, 2: W first
    task automatic axi_write(input logic [15:0] a, input logic [31:0] d,
                             input logic [3:0] be, input int mode, input int hold);
        q.push_back('{rd: 1'b0, a: a[15:2], d: d, be: be});
        s_awaddr = a; s_wdata = d; s_wstrb = be;
        if (mode == 1) begin
            hs(1, 0, 0);
            chk("R1 awready low while address held", {63'd0, s_awready}, 0);
            hs(0, 1, 0);
        end else if (mode == 2) begin
            hs(0, 1, 0);
            chk("R1 wready low while data held", {63'd0, s_wready}, 0);
            hs(1, 0, 0);
        end else begin
            hs(1, 1, 0);
        end
        while (!s_bvalid) @(negedge cpu_clk);
        chk("R3 bresp OKAY", {62'd0, s_bresp}, 0);
        for (int i = 0; i < hold; i++) begin
            @(negedge cpu_clk);
            chk("R3 bvalid held", {63'd0, s_bvalid}, 1);
        end
        s_bready = 1'b1;
        @(negedge cpu_clk);
        s_bready = 1'b0;
        chk("R3 bvalid drops after handshake", {63'd0, s_bvalid}, 0);
    endtask

    task automatic axi_read(input logic [15:0] a, input int hold);
        logic [31:0] got;
        q.push_back('{rd: 1'b1, a: a[15:2], d: 32'd0, be: 4'd0});
        s_araddr = a;
        hs(0, 0, 1);
        while (!s_rvalid) @(negedge cpu_clk);
        got = s_rdata;
        chk("R5 rdata", {32'd0, got}, {32'd0, pat(a[15:2])});
        chk("R5 rresp OKAY", {62'd0, s_rresp}, 0);
        for (int i = 0; i < hold; i++) begin
            @(negedge cpu_clk);
            chk("R5 rvalid held", {63'd0, s_rvalid}, 1);
            chk("R5 rdata stable", {32'd0, s_rdata}, {32'd0, got});
        end
        s_rready = 1'b1;
        @(negedge cpu_clk);
        s_rready = 1'b0;
        chk("R5 rvalid drops after handshake", {63'd0, s_rvalid}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge cpu_clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (8) @(negedge cpu_clk);
        cpu_rst_n = 1'b1; usr_rst_n = 1'b1;
        @(negedge cpu_clk);
        chk("R7 awready after reset", {63'd0, s_awready}, 1);
        chk("R7 wready after reset", {63'd0, s_wready}, 1);
        chk("R7 arready after reset", {63'd0, s_arready}, 1);
        chk("R7 bvalid after reset", {63'd0, s_bvalid}, 0);
        chk("R7 rvalid after reset", {63'd0, s_rvalid}, 0);

        axi_write(16'h0010, 32'h1122_3344, 4'hF, 0, 0);
        axi_write(16'h0024, 32'hDEAD_BEEF, 4'b0101, 1, 0);
        axi_write(16'h1000, 32'h0BAD_F00D, 4'b1000, 2, 3);
        axi_read(16'h0010, 0);
        axi_read(16'hFFFC, 4);

        // R6: write and read held together, write must reach the port first
        q.push_back('{rd: 1'b0, a: 14'h0010, d: 32'hCAFE_0001, be: 4'hF});
        q.push_back('{rd: 1'b1, a: 14'h0011, d: 32'd0, be: 4'd0});
        s_awaddr = 16'h0040; s_wdata = 32'hCAFE_0001; s_wstrb = 4'hF; s_araddr = 16'h0044;
        hs(1, 1, 1);
        begin
            logic gb, gr;
            gb = 1'b0; gr = 1'b0;
            s_bready = 1'b1; s_rready = 1'b1;
            while (!(gb && gr)) begin
                if (s_bvalid && !gb) begin
                    gb = 1'b1;
                    chk("R6 write response", {62'd0, s_bresp}, 0);
                end
                if (s_rvalid && !gr) begin
                    gr = 1'b1;
                    chk("R6 read data after write", {32'd0, s_rdata}, {32'd0, pat(14'h0011)});
                end
                @(negedge cpu_clk);
            end
            s_bready = 1'b0; s_rready = 1'b0;
        end

        for (int k = 0; k < 4; k++) axi_read(16'(16'h0200 + 4 * k), k % 2);
        for (int k = 0; k < 3; k++) axi_write(16'(16'h0300 + 4 * k), 32'h5000_0000 + k, 4'(k + 1), k, 0);

        repeat (10) @(negedge usr_clk);
        chk("R6 every transaction reached the register port", q.size(), 0);
        summary();
    end
endmodule